// File: doc/BRIEF.md
# Peripheral Run State Controller

This block holds the operating state of a serial peripheral core and moves it between three states: held in reset, running, and paused. Software asks for a state by writing a 2-bit code to a state register. It then reads back a settled flag that tells it when the transition has finished and a new request may be made. The block drives three level controls from the current state: a reset for the datapath, an enable for the shift engine and a freeze for the FIFOs. It also emits a one-cycle FIFO flush pulse each time the core enters reset.

Leaving pause is guarded. A direct request for reset while paused is refused. Software must write a separate clear code twice in a row, and the first clear only arms a one-deep pending flag. A second register takes a one-shot software reset that returns the core to reset from any state. That reset also emits a one-cycle pulse that the neighbouring operational, mode and mask registers use to clear themselves. A normal transfer moves from reset to run, then to pause while the output FIFO is pre-filled, then back to run, and finally to reset.

Top module: `run_state_ctrl`

## Requirements
- R1: After hardware reset the state field reads 0 (reset) and the settled flag reads 1. dp_reset is 1, shift_en, fifo_freeze, fifo_flush and regs_clear are 0, and illegal_req is 0.
- R2: The state register is read back on rd_state with the state field in bits [1:0]. When the core is not paused and the settled flag is 1, a write of code 0 (reset), 1 (run) or 3 (pause) to the state address puts that code in the field at the next clock edge.
- R3: The settled flag reads back in bit 2 of rd_state. After any accepted state change (including a software reset) it reads 0 for exactly SETTLE_CYCLES clock cycles and then returns to 1.
- R4: A state-register write that arrives while the settled flag is 0 leaves the state unchanged and sets illegal_req. illegal_req stays set until a software reset or a hardware reset.
- R5: While paused, a first write of the clear code 2 keeps the state at pause and leaves the settled flag at 1. A second clear code written as the next state-register write moves the state to reset.
- R6: While paused, any state-register write other than the clear code disarms a pending clear. Code 1 moves to run, code 3 stays in pause and settles, and code 0 leaves the state at pause without a settle. A clear write when not paused has no effect.
- R7: A write with data bit 0 set to the software-reset address moves the state to reset, disarms any pending clear, clears illegal_req and starts a settle even when the flag is 0. It also raises regs_clear for one cycle. With bit 0 clear the write has no effect.
- R8: shift_en is 1 exactly when the state is run, fifo_freeze exactly when it is pause, and dp_reset exactly when it is reset.
- R9: fifo_flush is a one-cycle pulse in the cycle after the state enters reset from another state, or after a software reset. It stays low for an accepted reset-code write while already in reset.
- R10: Bits above bit 2 of rd_state always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 2 | Write data: state code, or bit 0 as the software-reset request |
| rd_state | output | DATA_W | State register readback: state field [1:0], settled flag [2] |
| dp_reset | output | 1 | Datapath reset, high in the reset state |
| shift_en | output | 1 | Shift-engine enable, high in the run state |
| fifo_freeze | output | 1 | FIFO freeze, high in the pause state |
| fifo_flush | output | 1 | One-cycle FIFO flush on entry to reset |
| regs_clear | output | 1 | One-cycle clear pulse for the neighbouring registers after a software reset |
| illegal_req | output | 1 | Sticky flag for a write refused while not settled |

## Verification
The bench builds the block with SETTLE_CYCLES set to 3, a 4-bit address and a 32-bit readback. The short settle window means that random writes often land while the flag is low, so refused writes and the sticky flag get frequent exercise. It also lets long random runs pass through the pause, arm and clear sequence many times. Directed sequences cover the double clear, disarming by each other code, a reset code written in pause, a clear written outside pause and a software reset with bit 0 low and high.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  localparam logic [1:0] ST_RESET = 2'd0;
  localparam logic [1:0] ST_RUN   = 2'd1;
  localparam logic [1:0] ST_CLEAR = 2'd2;
  localparam logic [1:0] ST_PAUSE = 2'd3;

  typedef struct packed {
    logic [1:0] state;
    logic       pend;
    logic       accept;
    logic       flush;
  } rsc_step_t;

  // Outcome of one state-register write taken while settled.
  function automatic rsc_step_t rsc_next(input logic [1:0] cur,
                                         input logic       pend,
                                         input logic [1:0] code);
    rsc_step_t r;
    r.state  = cur;
    r.pend   = pend;
    r.accept = 1'b0;
    r.flush  = 1'b0;
    if (cur == ST_PAUSE) begin
      r.pend = 1'b0;
      case (code)
        ST_CLEAR: begin
          if (pend) begin
            r.state  = ST_RESET;
            r.accept = 1'b1;
            r.flush  = 1'b1;
          end else begin
            r.pend = 1'b1;
          end
        end
        ST_RUN: begin
          r.state  = ST_RUN;
          r.accept = 1'b1;
        end
        ST_PAUSE: r.accept = 1'b1;
        default: ;
      endcase
    end else if (code != ST_CLEAR) begin
      r.state  = code;
      r.pend   = 1'b0;
      r.accept = 1'b1;
      r.flush  = (code == ST_RESET) && (cur != ST_RESET);
    end
    return r;
  endfunction

endpackage

// File: rtl/rsc_wr_decode.sv
module rsc_wr_decode #(
  parameter int unsigned ADDR_W     = 4,
  parameter logic [ADDR_W-1:0] STATE_ADDR = 'd1,
  parameter logic [ADDR_W-1:0] SWRST_ADDR = 'd3
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_data,
  output logic              st_req,
  output logic [1:0]        st_code,
  output logic              swrst_req
);

  always_comb begin
    st_req    = wr_en && (wr_addr == STATE_ADDR);
    st_code   = wr_data;
    swrst_req = wr_en && (wr_addr == SWRST_ADDR) && wr_data[0];
  end

endmodule

// File: rtl/rsc_settle_timer.sv
module rsc_settle_timer #(
  parameter int unsigned SETTLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic valid
);

  localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic             last_tick;

  assign last_tick = (cnt_q == CNT_W'(1));
  assign valid     = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= LOAD;
    end else if (!valid) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  AST_SETTLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !valid); // R3
  AST_SETTLE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (last_tick && !start) |=> valid); // R3

endmodule

// File: rtl/rsc_state_core.sv
module rsc_state_core
  import rsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       st_req,
  input  logic [1:0] st_code,
  input  logic       swrst_req,
  input  logic       valid,
  output logic [1:0] state,
  output logic       settle_start,
  output logic       illegal,
  output logic       flush,
  output logic       regs_clr
);

  logic [1:0] state_q;
  logic       pend_q;
  logic       ill_q;
  logic       flush_q;
  logic       rclr_q;
  rsc_step_t  nxt;

  // Named events for the assertions.
  logic busy_write_evt;
  logic take_write_evt;
  logic clr_arm_evt;
  logic clr_fire_evt;

  always_comb begin
    nxt            = rsc_next(state_q, pend_q, st_code);
    busy_write_evt = st_req && !valid && !swrst_req;
    take_write_evt = st_req && valid && !swrst_req;
    clr_arm_evt    = take_write_evt && (state_q == ST_PAUSE) &&
                     (st_code == ST_CLEAR) && !pend_q;
    clr_fire_evt   = take_write_evt && (state_q == ST_PAUSE) &&
                     (st_code == ST_CLEAR) && pend_q;
    settle_start   = swrst_req || (take_write_evt && nxt.accept);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RESET;
      pend_q  <= 1'b0;
      ill_q   <= 1'b0;
      flush_q <= 1'b0;
      rclr_q  <= 1'b0;
    end else begin
      flush_q <= 1'b0;
      rclr_q  <= 1'b0;
      if (swrst_req) begin
        state_q <= ST_RESET;
        pend_q  <= 1'b0;
        ill_q   <= 1'b0;
        flush_q <= 1'b1;
        rclr_q  <= 1'b1;
      end else if (busy_write_evt) begin
        ill_q <= 1'b1;
      end else if (take_write_evt) begin
        state_q <= nxt.state;
        pend_q  <= nxt.pend;
        flush_q <= nxt.flush;
      end
    end
  end

  assign state    = state_q;
  assign illegal  = ill_q;
  assign flush    = flush_q;
  assign regs_clr = rclr_q;

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_write_evt |=> ($stable(state_q) && ill_q)); // R4
  AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ill_q && !swrst_req) |=> ill_q); // R4
  AST_SINGLE_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_arm_evt |=> (state_q == ST_PAUSE && pend_q && valid)); // R5
  AST_SECOND_CLEAR_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire_evt |=> (state_q == ST_RESET && flush_q && !pend_q)); // R5
  AST_PEND_ONLY_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (state_q == ST_PAUSE)); // R6
  AST_SWRST_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_req |=> (state_q == ST_RESET && rclr_q && !ill_q)); // R7
  AST_FLUSH_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> (state_q == ST_RESET)); // R9

endmodule

// File: rtl/run_state_ctrl.sv
module run_state_ctrl
  import rsc_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 4,
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned DATA_W        = 32,
  parameter logic [ADDR_W-1:0] STATE_ADDR = 'd1,
  parameter logic [ADDR_W-1:0] SWRST_ADDR = 'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_data,
  output logic [DATA_W-1:0] rd_state,
  output logic              dp_reset,
  output logic              shift_en,
  output logic              fifo_freeze,
  output logic              fifo_flush,
  output logic              regs_clear,
  output logic              illegal_req
);

  localparam int unsigned PAD_W = DATA_W - 3;

  logic       st_req;
  logic [1:0] st_code;
  logic       swrst_req;
  logic       valid;
  logic       settle_start;
  logic [1:0] state;

  rsc_wr_decode #(
    .ADDR_W    (ADDR_W),
    .STATE_ADDR(STATE_ADDR),
    .SWRST_ADDR(SWRST_ADDR)
  ) u_dec (
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .st_req   (st_req),
    .st_code  (st_code),
    .swrst_req(swrst_req)
  );

  rsc_settle_timer #(
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(settle_start),
    .valid(valid)
  );

  rsc_state_core u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_req      (st_req),
    .st_code     (st_code),
    .swrst_req   (swrst_req),
    .valid       (valid),
    .state       (state),
    .settle_start(settle_start),
    .illegal     (illegal_req),
    .flush       (fifo_flush),
    .regs_clr    (regs_clear)
  );

  assign rd_state    = {{PAD_W{1'b0}}, valid, state};
  assign dp_reset    = (state == ST_RESET);
  assign shift_en    = (state == ST_RUN);
  assign fifo_freeze = (state == ST_PAUSE);

  AST_FLUSH_HOLDS_DP: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> (dp_reset && !shift_en)); // R9
  AST_CLEAR_IMPLIES_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    regs_clear |-> !rd_state[2]); // R7

endmodule

// File: tb/run_state_ctrl_tb.sv
module run_state_ctrl_tb;

  localparam int unsigned S  = 3;
  localparam logic [3:0]  SA = 4'd1;
  localparam logic [3:0]  RA = 4'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [1:0]  wr_data = '0;
  logic [31:0] rd_state;
  logic        dp_reset, shift_en, fifo_freeze, fifo_flush, regs_clear, illegal_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Reference model state
  logic [1:0] m_state = 2'd0;
  logic       m_pend = 1'b0, m_ill = 1'b0, m_flush = 1'b0, m_rclr = 1'b0;
  int         m_cnt = 0;

  always #10 clk = ~clk;

  run_state_ctrl #(
    .SETTLE_CYCLES(S), .ADDR_W(4), .DATA_W(32),
    .STATE_ADDR(SA), .SWRST_ADDR(RA)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_state(rd_state), .dp_reset(dp_reset), .shift_en(shift_en),
    .fifo_freeze(fifo_freeze), .fifo_flush(fifo_flush),
    .regs_clear(regs_clear), .illegal_req(illegal_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] exp_ctrl(input logic [1:0] st);
    return {st == 2'd0, st == 2'd1, st == 2'd3};
  endfunction

  task automatic compare_all();
    check("R2 state field", {30'd0, rd_state[1:0]}, {30'd0, m_state});
    check("R3 settled flag", {31'd0, rd_state[2]}, {31'd0, m_cnt == 0});
    check("R10 upper bits", {3'd0, rd_state[31:3]}, 32'd0);
    check("R4 illegal flag", {31'd0, illegal_req}, {31'd0, m_ill});
    check("R8 controls", {29'd0, dp_reset, shift_en, fifo_freeze}, {29'd0, exp_ctrl(m_state)});
    check("R9 flush pulse", {31'd0, fifo_flush}, {31'd0, m_flush});
    check("R7 regs clear", {31'd0, regs_clear}, {31'd0, m_rclr});
  endtask

  // One clock: drive at a falling edge, update model, compare at the next falling edge.
  task automatic step(input logic we, input logic [3:0] a, input logic [1:0] d);
    logic [1:0] n_state;
    logic       n_pend, n_ill, n_flush, n_rclr;
    int         n_cnt;
    wr_en = we; wr_addr = a; wr_data = d;
    n_state = m_state; n_pend = m_pend; n_ill = m_ill;
    n_flush = 1'b0; n_rclr = 1'b0;
    n_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
    if (we && a == RA && d[0]) begin
      n_state = 2'd0; n_pend = 1'b0; n_ill = 1'b0;
      n_cnt = S; n_flush = 1'b1; n_rclr = 1'b1;
    end else if (we && a == SA) begin
      if (m_cnt != 0) begin
        n_ill = 1'b1;
      end else if (m_state == 2'd3) begin
        n_pend = 1'b0;
        if (d == 2'd2) begin
          if (m_pend) begin n_state = 2'd0; n_cnt = S; n_flush = 1'b1; end
          else n_pend = 1'b1;
        end else if (d == 2'd1) begin
          n_state = 2'd1; n_cnt = S;
        end else if (d == 2'd3) begin
          n_cnt = S;
        end
      end else if (d != 2'd2) begin
        n_flush = (d == 2'd0) && (m_state != 2'd0);
        n_state = d; n_cnt = S;
      end
    end
    @(posedge clk);
    @(negedge clk);
    m_state = n_state; m_pend = n_pend; m_ill = n_ill;
    m_flush = n_flush; m_rclr = n_rclr; m_cnt = n_cnt;
    wr_en = 1'b0;
    compare_all();
  endtask

  task automatic idle_until_settled();
    while (m_cnt != 0) step(1'b0, 4'd0, 2'd0);
  endtask

  task automatic wstate(input logic [1:0] code);
    idle_until_settled();
    step(1'b1, SA, code);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1 reset state word", rd_state, 32'h0000_0004);
    check("R1 reset controls", {27'd0, dp_reset, shift_en, fifo_freeze, fifo_flush, regs_clear},
          32'b10000);
    check("R1 reset illegal", {31'd0, illegal_req}, 32'd0);

    // R2 / R3: run, then exact settle window
    step(1'b1, SA, 2'd1);
    check("R2 run taken", {30'd0, rd_state[1:0]}, 32'd1);
    // R3: flag low for S cycles (one already seen), then high
    for (int i = 1; i < S; i++) begin
      step(1'b0, 4'd0, 2'd0);
      check("R3 still settling", {31'd0, rd_state[2]}, 32'd0);
    end
    step(1'b0, 4'd0, 2'd0);
    check("R3 settled again", {31'd0, rd_state[2]}, 32'd1);

    // R5: double clear from pause
    wstate(2'd3);
    wstate(2'd2);
    check("R5 first clear keeps pause", {30'd0, rd_state[1:0]}, 32'd3);
    check("R5 first clear no settle", {31'd0, rd_state[2]}, 32'd1);
    step(1'b0, 4'd0, 2'd0);
    wstate(2'd2);
    check("R5 second clear resets", {30'd0, rd_state[1:0]}, 32'd0);
    check("R9 flush on clear exit", {31'd0, fifo_flush}, 32'd1);

    // R6: disarm by run code
    wstate(2'd1); wstate(2'd3); wstate(2'd2); wstate(2'd1);
    check("R6 run code leaves pause", {30'd0, rd_state[1:0]}, 32'd1);
    // R6: reset code in pause ignored and disarms
    wstate(2'd3); wstate(2'd2); wstate(2'd0);
    check("R6 reset code in pause ignored", {30'd0, rd_state[1:0]}, 32'd3);
    wstate(2'd2);
    check("R6 disarmed clear holds pause", {30'd0, rd_state[1:0]}, 32'd3);
    wstate(2'd2);
    check("R6 rearmed clear resets", {30'd0, rd_state[1:0]}, 32'd0);
    // R6: clear outside pause
    wstate(2'd2);
    check("R6 clear outside pause", rd_state, 32'h0000_0004);
    // R9: reset code while in reset: no flush
    wstate(2'd0);
    check("R9 no flush reset->reset", {31'd0, fifo_flush}, 32'd0);

    // R4: write while settling
    wstate(2'd1);
    step(1'b1, SA, 2'd3);
    check("R4 busy write ignored", {30'd0, rd_state[1:0]}, 32'd1);
    check("R4 illegal set", {31'd0, illegal_req}, 32'd1);
    idle_until_settled();
    wstate(2'd3);
    check("R4 illegal sticky", {31'd0, illegal_req}, 32'd1);

    // R7: software reset
    step(1'b1, RA, 2'd2);
    check("R7 bit0 low no effect", {30'd0, rd_state[1:0]}, 32'd3);
    step(1'b1, RA, 2'd1);
    check("R7 swrst to reset", {30'd0, rd_state[1:0]}, 32'd0);
    check("R7 swrst clears illegal", {31'd0, illegal_req}, 32'd0);
    check("R7 regs clear pulse", {31'd0, regs_clear}, 32'd1);
    step(1'b1, RA, 2'd1);
    check("R7 swrst while settling", {31'd0, illegal_req}, 32'd0);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 45)      step(1'b0, 4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)));
      else if (r < 88) step(1'b1, SA, 2'($urandom_range(0, 3)));
      else if (r < 93) step(1'b1, RA, 2'($urandom_range(0, 3)));
      else             step(1'b1, 4'd7, 2'($urandom_range(0, 3)));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule